// File: doc/BRIEF.md
# Set/Clear Interprocessor Mailbox Bank

This block holds one 32-bit mailbox word per (core, slot) pair: four slots for each of four cores by default, sixteen words in all. It sits behind a simple single-cycle register port made of valid, write, address and write-data lines. A core raises a message by writing a mask into the set window of the register space, and that mask is ORed into the chosen word. The receiving core reads the word through the clear window, then writes back the bits it has handled through that same window to drop them.

Each word drives its own pending line. A pending line stays high while any bit of its word is one. A downstream interrupt router decides what those lines mean to each core. Mailbox slot `s` of core `c` sits at index `c*BOX_PER_CORE + s`. The set window starts at byte offset 0x80 and the clear window starts at 0xC0. Each word takes four bytes, so the register space ends at 0x100.

Top module: `mbx_bank`

## Requirements
- R1: While `rst_n` is low, and after it has been low, every mailbox word is zero, every `box_pending` bit is 0 and `rd_data` is 0.
- R2: A write to byte offset 0x80 + 4*i, with i from 0 to 15, ORs `acc_wdata` into mailbox i. The new value is visible the cycle after the write.
- R3: A write to byte offset 0xC0 + 4*i clears each bit of mailbox i where `acc_wdata` holds a one. The other bits of that mailbox keep their value.
- R4: A read at byte offset 0xC0 + 4*i returns the current value of mailbox i on `rd_data` in the cycle after the read is presented.
- R5: `rd_data` is zero in the cycle after a read in the set window (0x80 to 0xBF), a read at or above 0x100 or below 0x80, or a read whose address bits [1:0] are not 00. It is also zero in the cycle after any cycle that carries no read.
- R6: `box_pending[i]` is 1 exactly when mailbox i is nonzero. It follows each write one cycle after the write.
- R7: Writes that change no mailbox: a write with `acc_valid` low, a write to an address outside 0x80 to 0xFF, and a write whose address bits [1:0] are not 00.
- R8: A write of all-zero data leaves the mailbox unchanged, in both the set window and the clear window.
- R9: A write changes only the one mailbox it addresses. All other mailboxes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (12) | Byte offset of the access |
| acc_wdata | input | DATA_W (32) | Write data / bit mask |
| rd_data | output | DATA_W (32) | Read data, valid the cycle after a read |
| box_pending | output | NUM_CORES*BOX_PER_CORE (16) | One flag per mailbox, high while the word is nonzero |

## Verification
The bench builds the block with its default parameters: four cores, four slots per core, 32-bit words, a 12-bit address and a registered read path. The 12-bit address lets the bench reach offsets at and above 0x100 and below 0x80, so the window edges are tested from both sides. The bench sets a different bit pattern in each of the sixteen words. That makes the index arithmetic for every core and slot visible, and a write that lands on the wrong word shows up as a mismatch. A stretch of pseudo-random accesses then mixes aligned and misaligned addresses in every window against the behavioural model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_SET  = 2'd1,
      WIN_CLR  = 2'd2
   } mbx_win_e;

   function automatic logic addr_in(input logic [31:0] a, input logic [31:0] lo,
                                    input logic [31:0] hi);
      return (a >= lo) && (a < hi);
   endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
   import mbx_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int NBOX     = 16,
   parameter int IDX_W    = 4,
   parameter int SET_BASE = 128
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic [NBOX-1:0]   set_hit,
   output logic [NBOX-1:0]   clr_hit,
   output logic              rd_hit,
   output logic [IDX_W-1:0]  rd_idx
);
   localparam logic [31:0] SET_LO = 32'(SET_BASE);
   localparam logic [31:0] CLR_LO = SET_LO + 32'(4 * NBOX);
   localparam logic [31:0] WIN_HI = CLR_LO + 32'(4 * NBOX);

   logic [31:0]    a32;
   logic [31:0]    offs;
   mbx_win_e       win;
   logic [IDX_W-1:0] idx;

   assign a32 = 32'(acc_addr);

   always_comb begin
      win  = WIN_NONE;
      offs = '0;
      if (a32[1:0] == 2'b00) begin
         if (addr_in(a32, SET_LO, CLR_LO)) begin
            win  = WIN_SET;
            offs = a32 - SET_LO;
         end else if (addr_in(a32, CLR_LO, WIN_HI)) begin
            win  = WIN_CLR;
            offs = a32 - CLR_LO;
         end
      end
   end

   assign idx = offs[IDX_W+1:2];

   always_comb begin
      set_hit = '0;
      clr_hit = '0;
      if (acc_valid && acc_write) begin
         if (win == WIN_SET) set_hit[idx] = 1'b1;
         if (win == WIN_CLR) clr_hit[idx] = 1'b1;
      end
   end

   assign rd_hit = acc_valid && !acc_write && (win == WIN_CLR);
   assign rd_idx = idx;
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic              clr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] value,
   output logic              pending
);
   always_ff @(posedge clk) begin
      if (!rst_n)      value <= '0;
      else if (set_en) value <= value | wdata;
      else if (clr_en) value <= value & ~wdata;
   end

   assign pending = |value;

   AST_SET_HOLDS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ((value & $past(wdata)) == $past(wdata)));               // R2
   AST_CLR_DROPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((value & $past(wdata)) == '0));           // R3
   AST_NONZERO_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && (wdata != '0)) |=> pending);                            // R6
   AST_ZERO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_en || clr_en) && (wdata == '0)) |=> $stable(value));         // R8
   AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en) |=> $stable(value));                          // R9
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux #(
   parameter int DATA_W = 32,
   parameter int NBOX   = 16,
   parameter int IDX_W  = 4
) (
   input  logic [NBOX-1:0][DATA_W-1:0] values,
   input  logic                        rd_hit,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [DATA_W-1:0]           rdata
);
   always_comb begin
      rdata = '0;
      for (int k = 0; k < NBOX; k++) begin
         if (rd_hit && (rd_idx == IDX_W'(k))) rdata = values[k];
      end
   end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
   parameter int NUM_CORES    = 4,
   parameter int BOX_PER_CORE = 4,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 12,
   parameter int SET_BASE     = 128,
   parameter bit RD_PIPE      = 1'b1,
   localparam int NBOX        = NUM_CORES * BOX_PER_CORE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic [NBOX-1:0]   box_pending
);
   localparam int IDX_W    = (NBOX > 1) ? $clog2(NBOX) : 1;
   localparam int SPAN_END = SET_BASE + 8 * NBOX;

   if (SET_BASE % 4 != 0) begin : g_bad_base
      $error("mbx_bank: SET_BASE must be word aligned");
   end
   if (SPAN_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("mbx_bank: ADDR_W too narrow for both windows");
   end
   if (NBOX < 1 || DATA_W < 1) begin : g_bad_size
      $error("mbx_bank: need at least one mailbox bit");
   end

   logic [NBOX-1:0]             set_hit;
   logic [NBOX-1:0]             clr_hit;
   logic                        rd_hit;
   logic [IDX_W-1:0]            rd_idx;
   logic [NBOX-1:0][DATA_W-1:0] box_val;
   logic [DATA_W-1:0]           mux_out;

   mbx_decode #(
      .ADDR_W(ADDR_W), .NBOX(NBOX), .IDX_W(IDX_W), .SET_BASE(SET_BASE)
   ) u_decode (
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .set_hit(set_hit), .clr_hit(clr_hit), .rd_hit(rd_hit), .rd_idx(rd_idx)
   );

   for (genvar g = 0; g < NBOX; g++) begin : g_box
      mbx_cell #(.DATA_W(DATA_W)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .set_en(set_hit[g]), .clr_en(clr_hit[g]), .wdata(acc_wdata),
         .value(box_val[g]), .pending(box_pending[g])
      );
   end

   mbx_rdmux #(.DATA_W(DATA_W), .NBOX(NBOX), .IDX_W(IDX_W)) u_rdmux (
      .values(box_val), .rd_hit(rd_hit), .rd_idx(rd_idx), .rdata(mux_out)
   );

   if (RD_PIPE) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= mux_out;
      end
      AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_hit |=> (rd_data == '0));                                   // R5
   end else begin : g_rd_comb
      assign rd_data = mux_out;
   end

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_hit, clr_hit}));                                     // R9
   AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write) |=> $stable(box_pending));               // R7
endmodule

// File: tb/tb_mbx_bank.sv
module tb_mbx_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] rd_data;
   logic [15:0] box_pending;

   always #10 clk = ~clk;

   mbx_bank dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
      .box_pending(box_pending)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] mdl [16];
   logic [31:0] exp_rd = '0;
   string       prev_tag = "R1";
   logic [31:0] lfsr = 32'h1ACE_B00C;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare();
      logic [15:0] ep;
      for (int i = 0; i < 16; i++) ep[i] = (mdl[i] != 32'd0);
      check(prev_tag, rd_data, exp_rd);
      check("R6", {16'd0, box_pending}, {16'd0, ep});
   endtask

   task automatic cyc(input bit v, input bit w, input int a, input logic [31:0] d,
                      input string tag);
      @(negedge clk);
      compare();
      acc_valid = v; acc_write = w; acc_addr = 12'(a); acc_wdata = d;
      exp_rd = 32'd0;
      if (v && (a % 4 == 0)) begin
         if (!w && a >= 192 && a < 256) exp_rd = mdl[(a - 192) / 4];
         if (w && a >= 128 && a < 192) mdl[(a - 128) / 4] = mdl[(a - 128) / 4] | d;
         if (w && a >= 192 && a < 256) mdl[(a - 192) / 4] = mdl[(a - 192) / 4] & ~d;
      end
      prev_tag = tag;
   endtask

   task automatic do_reset();
      @(negedge clk);
      compare();
      rst_n = 1'b0; acc_valid = 1'b0;
      for (int i = 0; i < 16; i++) mdl[i] = 32'd0;
      exp_rd = 32'd0;
      prev_tag = "R1";
      @(negedge clk);
      compare();
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) mdl[i] = 32'd0;
      repeat (2) @(negedge clk);
      do_reset();
      cyc(0, 0, 0, 0, "R1");
      // R2 / R4: set and OR-accumulate, read back through clear window
      cyc(1, 1, 128, 32'h0000_0001, "R2");
      cyc(1, 0, 192, 0, "R4");
      cyc(1, 1, 128, 32'h8000_0000, "R2");
      cyc(1, 0, 192, 0, "R4");
      // R9: distinct pattern in every mailbox
      for (int i = 0; i < 16; i++) cyc(1, 1, 128 + 4 * i, 32'(i + 1) << i, "R9");
      for (int i = 0; i < 16; i++) cyc(1, 0, 192 + 4 * i, 0, "R4");
      // R3: partial then full clear
      cyc(1, 1, 192 + 20, 32'h0000_0040, "R3");
      cyc(1, 0, 192 + 20, 0, "R3");
      cyc(1, 1, 192 + 20, 32'hFFFF_FFFF, "R3");
      cyc(1, 0, 192 + 20, 0, "R3");
      // R8: zero data in both windows
      cyc(1, 1, 128 + 12, 32'd0, "R8");
      cyc(1, 1, 192 + 12, 32'd0, "R8");
      cyc(1, 0, 192 + 12, 0, "R8");
      // R5: unmapped reads
      cyc(1, 0, 132, 0, "R5");
      cyc(1, 0, 256, 0, "R5");
      cyc(1, 0, 124, 0, "R5");
      cyc(1, 0, 193, 0, "R5");
      cyc(0, 0, 196, 0, "R5");
      // R7: ignored writes
      cyc(1, 1, 130, 32'hFFFF_FFFF, "R7");
      cyc(1, 1, 256, 32'hFFFF_FFFF, "R7");
      cyc(1, 1, 64, 32'hFFFF_FFFF, "R7");
      cyc(0, 1, 128 + 20, 32'hFFFF_FFFF, "R7");
      cyc(0, 1, 192, 32'hFFFF_FFFF, "R7");
      cyc(1, 0, 192 + 20, 0, "R7");
      cyc(1, 0, 192, 0, "R7");
      // mixed pseudo-random traffic
      for (int n = 0; n < 400; n++) begin
         int a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = 112 + int'(lfsr[7:0] % 8'd160);
         if (lfsr[9:8] == 2'b00) a = a & ~3;
         else a = a & ~3 | int'(lfsr[12] & lfsr[13]);
         cyc(lfsr[14] | lfsr[15], lfsr[16], a,
             lfsr[17] ? 32'(1) << lfsr[22:18] : {lfsr[31:24], lfsr[7:0], lfsr[23:8]},
             "R9");
      end
      // R1: reset mid-run clears everything
      do_reset();
      for (int i = 0; i < 16; i++) cyc(1, 0, 192 + 4 * i, 0, "R1");
      cyc(0, 0, 0, 0, "R1");
      @(negedge clk);
      compare();
      finish_run();
   end
endmodule